// File: doc/BRIEF.md
# Cascaded Second-Order Fixed-Point IIR Filter

This block filters a stream of signed 24-bit fractional samples through a chain of second-order sections. Each section keeps two state words between samples. It forms its output as the first state plus a feed-through term. It then updates both states from the section's input and its output, which is a transposed state-space arrangement. The output of one section is the input of the next, and the last section's output is the filter result.

All six per-section coefficients (five transfer-function coefficients and one input scale) are stored at half their true value, so that gains up to two fit inside the fractional word range. A single shared 24x24 multiplier with a 56-bit accumulator does the arithmetic. Every result moves from the accumulator to a data word by the same path: the accumulator is doubled, rounded to nearest, and saturated. The sections are worked through one after another, seven cycles each.

Software loads the coefficients through a write port. The same port can preset either state of any section to any value, including the ends of the number range. A sample is accepted on a strobe while the engine is idle. A one-cycle done pulse marks the moment the new output is valid.

Top module: `iir_sos_cascade`

## Requirements
- R1: With section input x and stored half-coefficients (a0h, a1h, a2h, b0h, b1h, kh), and with all numbers Q1.23 and W(v) = sat(round(2·v)), each section computes xs = W(kh·x), y = W(a2h·xs + v1/2), v1' = W(a1h·xs − b1h·y + v2/2) and v2' = W(a0h·xs − b0h·y).
- R2: Rounding adds half an LSB of the 24-bit result before truncation: word = floor((2·acc + 2^22) / 2^23) when acc is held as an integer in units of 2^-46.
- R3: The output y of section k feeds section k+1. out_data carries the y of the last section and changes only in the cycle in which out_done is high.
- R4: Every word written back from the accumulator saturates to the range −2^23 to 2^23−1, as raw two's-complement values.
- R5: The states v1 and v2 of every section are held from one sample to the next, and a write can preset them to any 24-bit value.
- R6: cfg_addr is {section index, field}, with the field in the low 3 bits: 0 a0h, 1 a1h, 2 a2h, 3 b0h, 4 b1h, 5 kh, 6 v1, 7 v2. cfg_wdata is written when cfg_we is high and the engine is idle.
- R7: out_done is a single-cycle pulse. It rises on the 7·NSEC-th clock edge after the edge that accepts the sample.
- R8: An in_valid sample is accepted only while busy is low. busy stays high from the accepting edge until out_done rises. A strobe while busy is ignored and produces no extra result.
- R9: A configuration write while busy is high changes neither a coefficient nor a state.
- R10: A synchronous active-low reset clears all states, all coefficients, out_data, out_done and busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Input sample, Q1.23 |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | SW+3 | Section index and field code |
| cfg_wdata | input | DW | Coefficient or state value |
| busy | output | 1 | Engine working on a sample |
| out_data | output | DW | Filtered output, Q1.23 |
| out_done | output | 1 | Output valid pulse |

## Verification
The assertions watch the handshake timing on every cycle. They check that out_done is a single pulse, that it arrives after exactly 7·NSEC busy cycles, that it ends busy, that an idle strobe starts the engine, and that out_data moves only with out_done. The arithmetic can only be shown by the bench scenarios, which compare each result with a bit-exact model. These cover rounding, saturation at both range ends, extreme preset states, cascading, and writes or strobes that arrive while busy and must be ignored.

// File: rtl/iir_sos_pkg.sv
// Shared definitions for the cascaded second-order filter.
// Assumes: step ordering below is the engine's fixed schedule per section.
package iir_sos_pkg;

    // Operation applied by the multiply-accumulate unit in one cycle
    typedef enum logic [1:0] {
        MAC_IDLE,
        MAC_LOAD,
        MAC_ADD,
        MAC_SUB
    } mac_op_e;

    // Per-section schedule, one step per clock
    typedef enum logic [2:0] {
        STP_SCALE,
        STP_OUT,
        STP_V1A,
        STP_V1B,
        STP_V2A,
        STP_V2B,
        STP_WB
    } step_e;

    localparam int STEPS_PER_SEC = 7;
    localparam int FIELD_W       = 3;
    localparam int NUM_COEF      = 6;

    // Field codes in the low bits of the configuration address
    localparam logic [FIELD_W-1:0] FLD_A0 = 3'd0;
    localparam logic [FIELD_W-1:0] FLD_A1 = 3'd1;
    localparam logic [FIELD_W-1:0] FLD_A2 = 3'd2;
    localparam logic [FIELD_W-1:0] FLD_B0 = 3'd3;
    localparam logic [FIELD_W-1:0] FLD_B1 = 3'd4;
    localparam logic [FIELD_W-1:0] FLD_K  = 3'd5;
    localparam logic [FIELD_W-1:0] FLD_V1 = 3'd6;
    localparam logic [FIELD_W-1:0] FLD_V2 = 3'd7;

endpackage

// File: rtl/iir_sos_mac.sv
// Shared multiply-accumulate unit with a doubling, rounding, saturating
// narrowing path from the accumulator to a data word.
// Assumes: AW > 2*DW so that sums of a few products cannot wrap.
module iir_sos_mac
    import iir_sos_pkg::*;
#(
    parameter int DW = 24,
    parameter int AW = 56
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  mac_op_e              op,
    input  logic signed [DW-1:0] opa,
    input  logic signed [DW-1:0] opb,
    input  logic signed [AW-1:0] base,
    output logic signed [DW-1:0] sat_word
);
    localparam int PW   = 2 * DW;
    localparam int FRAC = DW - 1;
    localparam logic signed [DW-1:0] WMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] WMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [AW:0]   RND  = {{(AW+1-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

    logic signed [AW-1:0] acc;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;
    logic signed [AW:0]   dbl;
    logic signed [AW:0]   q;
    logic                 in_range;

    // Full-precision product, sign-extended to accumulator width
    always_comb begin
        prod     = opa * opb;
        prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
    end

    // Accumulator update for the requested operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            case (op)
                MAC_LOAD: acc <= base + prod_ext;
                MAC_ADD:  acc <= acc + prod_ext;
                MAC_SUB:  acc <= acc - prod_ext;
                default:  acc <= acc;
            endcase
        end
    end

    // Double, round to nearest, narrow and saturate
    always_comb begin
        dbl      = {acc, 1'b0};
        q        = (dbl + RND) >>> FRAC;
        in_range = (&q[AW:DW-1]) || !(|q[AW:DW-1]);
        if (in_range)
            sat_word = q[DW-1:0];
        else if (q[AW])
            sat_word = WMIN;
        else
            sat_word = WMAX;
    end

endmodule

// File: rtl/iir_sos_ctrl.sv
// Sequencer: walks sections 0..NSEC-1, seven steps each, per accepted sample.
// Assumes: start is ignored while busy.
module iir_sos_ctrl
    import iir_sos_pkg::*;
#(
    parameter int NSEC = 4,
    parameter int SW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [SW-1:0] sec,
    output step_e         step,
    output logic          finish
);
    // Section/step counters and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sec  <= '0;
            step <= STP_SCALE;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                sec  <= '0;
                step <= STP_SCALE;
            end
        end else if (step == STP_WB) begin
            step <= STP_SCALE;
            if (sec == SW'(NSEC - 1))
                busy <= 1'b0;
            else
                sec <= sec + 1'b1;
        end else begin
            step <= step_e'(step + 3'd1);
        end
    end

    // Last write-back step of the last section
    assign finish = busy && (step == STP_WB) && (sec == SW'(NSEC - 1));

endmodule

// File: rtl/iir_sos_regfile.sv
// Per-section coefficient and state storage with one configuration write
// port, one engine state write port and one section read port.
// Assumes: the top gates cfg_en off while the engine is busy.
module iir_sos_regfile
    import iir_sos_pkg::*;
#(
    parameter int NSEC = 4,
    parameter int DW   = 24,
    parameter int SW   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_en,
    input  logic [SW-1:0]                    cfg_sec,
    input  logic [FIELD_W-1:0]               cfg_fld,
    input  logic [DW-1:0]                    cfg_data,
    input  logic                             st_we,
    input  logic [SW-1:0]                    st_sec,
    input  logic [DW-1:0]                    st_v1,
    input  logic [DW-1:0]                    st_v2,
    input  logic [SW-1:0]                    rd_sec,
    output logic [NUM_COEF-1:0][DW-1:0]      rd_coef,
    output logic [DW-1:0]                    rd_v1,
    output logic [DW-1:0]                    rd_v2
);
    logic [NUM_COEF-1:0][DW-1:0] coef_all [NSEC];
    logic [DW-1:0]               v1_all   [NSEC];
    logic [DW-1:0]               v2_all   [NSEC];

    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        logic [NUM_COEF-1:0][DW-1:0] c_q;
        logic [DW-1:0]               v1_q;
        logic [DW-1:0]               v2_q;
        logic                        cfg_hit;
        logic                        st_hit;

        assign cfg_hit = cfg_en && (cfg_sec == SW'(g));
        assign st_hit  = st_we && (st_sec == SW'(g));

        // Storage for this section: configuration writes, then engine updates
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c_q  <= '0;
                v1_q <= '0;
                v2_q <= '0;
            end else if (cfg_hit) begin
                case (cfg_fld)
                    FLD_V1:  v1_q <= cfg_data;
                    FLD_V2:  v2_q <= cfg_data;
                    default: c_q[cfg_fld] <= cfg_data;
                endcase
            end else if (st_hit) begin
                v1_q <= st_v1;
                v2_q <= st_v2;
            end
        end

        assign coef_all[g] = c_q;
        assign v1_all[g]   = v1_q;
        assign v2_all[g]   = v2_q;
    end

    // Read port for the section being processed
    always_comb begin
        rd_coef = coef_all[rd_sec];
        rd_v1   = v1_all[rd_sec];
        rd_v2   = v2_all[rd_sec];
    end

endmodule

// File: rtl/iir_sos_cascade.sv
// Cascade of NSEC second-order sections in transposed state-space form,
// evaluated one section at a time on a shared MAC.
// Assumes: coefficients are stored halved; results are doubled on narrowing.
module iir_sos_cascade
    import iir_sos_pkg::*;
#(
    parameter int NSEC = 4,
    parameter int DW   = 24,
    parameter int AW   = 56,
    localparam int SW  = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    input  logic                 cfg_we,
    input  logic [SW+FIELD_W-1:0] cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output logic                 busy,
    output logic [DW-1:0]        out_data,
    output logic                 out_done
);
    localparam int HALF_SH = DW - 2;

    logic                        cfg_en;
    logic [SW-1:0]               sec;
    step_e                       step;
    logic                        finish;
    logic [NUM_COEF-1:0][DW-1:0] coef;
    logic [DW-1:0]               v1_rd, v2_rd;
    mac_op_e                     op;
    logic signed [DW-1:0]        opa, opb, sat_word;
    logic signed [AW-1:0]        base;
    logic signed [DW-1:0]        cur_x, xs_q, y_q, v1n_q;
    logic                        st_we;

    // A state word as half its value in accumulator units
    function automatic logic signed [AW-1:0] half_state(input logic [DW-1:0] v);
        logic signed [AW-1:0] e;
        e = {{(AW-DW){v[DW-1]}}, v};
        return e <<< HALF_SH;
    endfunction

    assign cfg_en = cfg_we && !busy;

    iir_sos_ctrl #(.NSEC(NSEC), .SW(SW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (in_valid),
        .busy   (busy),
        .sec    (sec),
        .step   (step),
        .finish (finish)
    );

    iir_sos_regfile #(.NSEC(NSEC), .DW(DW), .SW(SW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_sec  (cfg_addr[FIELD_W +: SW]),
        .cfg_fld  (cfg_addr[FIELD_W-1:0]),
        .cfg_data (cfg_wdata),
        .st_we    (st_we),
        .st_sec   (sec),
        .st_v1    (v1n_q),
        .st_v2    (sat_word),
        .rd_sec   (sec),
        .rd_coef  (coef),
        .rd_v1    (v1_rd),
        .rd_v2    (v2_rd)
    );

    iir_sos_mac #(.DW(DW), .AW(AW)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .opa      (opa),
        .opb      (opb),
        .base     (base),
        .sat_word (sat_word)
    );

    // Operand selection for the current step
    always_comb begin
        op    = MAC_IDLE;
        opa   = '0;
        opb   = '0;
        base  = '0;
        st_we = 1'b0;
        if (busy) begin
            case (step)
                STP_SCALE: begin op = MAC_LOAD; opa = coef[FLD_K];  opb = cur_x; end
                STP_OUT:   begin op = MAC_LOAD; opa = coef[FLD_A2]; opb = sat_word;
                                 base = half_state(v1_rd); end
                STP_V1A:   begin op = MAC_LOAD; opa = coef[FLD_A1]; opb = xs_q;
                                 base = half_state(v2_rd); end
                STP_V1B:   begin op = MAC_SUB;  opa = coef[FLD_B1]; opb = y_q; end
                STP_V2A:   begin op = MAC_LOAD; opa = coef[FLD_A0]; opb = xs_q; end
                STP_V2B:   begin op = MAC_SUB;  opa = coef[FLD_B0]; opb = y_q; end
                default:   st_we = 1'b1;
            endcase
        end
    end

    // Capture of narrowed intermediate words and the section-to-section handoff
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= '0;
            xs_q  <= '0;
            y_q   <= '0;
            v1n_q <= '0;
        end else if (!busy) begin
            if (in_valid) cur_x <= in_data;
        end else begin
            case (step)
                STP_OUT: xs_q  <= sat_word;
                STP_V1A: y_q   <= sat_word;
                STP_V2A: v1n_q <= sat_word;
                STP_WB:  cur_x <= y_q;
                default: ;
            endcase
        end
    end

    // Result register and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_done <= 1'b0;
        end else begin
            out_done <= finish;
            if (finish) out_data <= y_q;
        end
    end

endmodule

// File: rtl/iir_sos_cascade_chk.sv
// Timing checker for the cascade's sample handshake, bound to the top.
// Assumes: outputs are registered on the rising edge of clk.
module iir_sos_cascade_chk #(
    parameter int NSEC = 4,
    parameter int DW   = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          busy,
    input logic [DW-1:0] out_data,
    input logic          out_done
);
    localparam int RUN = 7 * NSEC;

    int run_cnt;

    // Counts consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);                                   // R7
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> run_cnt == RUN);                              // R7
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_cnt < RUN);                                   // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (!busy && $past(busy)));                      // R8
    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy);                             // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> $stable(out_data));                          // R3

endmodule

bind iir_sos_cascade iir_sos_cascade_chk #(.NSEC(NSEC), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .busy     (busy),
    .out_data (out_data),
    .out_done (out_done)
);

// File: tb/sim_iir_sos_cascade.sv
// Bench: directed corners plus seeded random coefficients and samples,
// compared with a bit-exact model of the section equations.
module sim_iir_sos_cascade;
    localparam int NSEC = 4;
    localparam int DW   = 24;
    localparam int SW   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DW-1:0]     in_data = '0;
    logic              cfg_we = 1'b0;
    logic [SW+2:0]     cfg_addr = '0;
    logic [DW-1:0]     cfg_wdata = '0;
    logic              busy;
    logic [DW-1:0]     out_data;
    logic              out_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Model: mc[s][f] with f 0 a0h,1 a1h,2 a2h,3 b0h,4 b1h,5 kh
    int mc  [NSEC][6];
    int mv1 [NSEC];
    int mv2 [NSEC];

    always #10 clk = ~clk;

    iir_sos_cascade #(.NSEC(NSEC), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .busy(busy), .out_data(out_data), .out_done(out_done)
    );

    function automatic int sx(input logic [DW-1:0] d);
        return {{(32-DW){d[DW-1]}}, d};
    endfunction

    function automatic longint satr(input longint acc);
        longint t;
        t = ((acc <<< 1) + 64'sd4194304) >>> 23;
        if (t > 64'sd8388607)  t = 64'sd8388607;
        if (t < -64'sd8388608) t = -64'sd8388608;
        return t;
    endfunction

    function automatic int model_run(input int x);
        longint xi, xs, y, n1, n2;
        xi = x;
        for (int k = 0; k < NSEC; k++) begin
            xs = satr(longint'(mc[k][5]) * xi);
            y  = satr(longint'(mc[k][2]) * xs + (longint'(mv1[k]) <<< 22));
            n1 = satr(longint'(mc[k][1]) * xs + (longint'(mv2[k]) <<< 22)
                      - longint'(mc[k][4]) * y);
            n2 = satr(longint'(mc[k][0]) * xs - longint'(mc[k][3]) * y);
            mv1[k] = int'(n1);
            mv2[k] = int'(n2);
            xi = y;
        end
        return int'(xi);
    endfunction

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < NSEC; k++) begin
            for (int f = 0; f < 6; f++) mc[k][f] = 0;
            mv1[k] = 0;
            mv2[k] = 0;
        end
    endtask

    // Idle write; the model mirrors it (R6 address map)
    task automatic cfg_write(input int s, input int f, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {SW'(s), 3'(f)};
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (f < 6) mc[s][f] = sx(d);
        else if (f == 6) mv1[s] = sx(d);
        else mv2[s] = sx(d);
    endtask

    task automatic program_all(input int f, input logic [DW-1:0] d);
        for (int s = 0; s < NSEC; s++) cfg_write(s, f, d);
    endtask

    // Sample run; inj 1 = cfg write while busy (R9), 2 = strobe while busy (R8)
    task automatic run_sample(input int x, input int inj, input string req, output int got);
        int cnt, exp;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(x);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        cnt = 1;
        exp = model_run(x);
        while (!out_done && cnt < 1000) begin
            if (inj == 1 && cnt == 3) begin
                cfg_we = 1'b1; cfg_addr = {SW'(0), 3'd2}; cfg_wdata = DW'($urandom);
            end else if (inj == 2 && cnt == 3) begin
                in_valid = 1'b1; in_data = DW'($urandom);
            end else begin
                cfg_we = 1'b0; in_valid = 1'b0;
            end
            if (inj != 0 && cnt == 4) check(int'(busy), 1, "R8 busy during run");
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        in_valid = 1'b0;
        got = sx(out_data);
        check(got, exp, req);
        check(cnt, 7 * NSEC + 1, "R7 done latency");
        check(int'(busy), 0, "R8 busy clear at done");
        @(negedge clk);
        check(int'(out_done), 0, "R7 done single pulse");
    endtask

    initial begin
        int got;
        void'($urandom(32'd20240611));
        model_clear();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        check(int'(out_data), 0, "R10 out_data reset");
        check(int'(busy), 0, "R10 busy reset");
        check(int'(out_done), 0, "R10 done reset");

        // R1/R2: kh=0.5 (gain 1), a2h=0.25 (gain 0.5), 0.125 in -> 0.125/16
        program_all(5, 24'h400000);
        program_all(2, 24'h200000);
        run_sample(24'h100000, 0, "R1 half gain per section", got);
        check(got, 65536, "R1 literal result");
        // R2: 3 LSB halved four times with round half up: 3->2->1->1->1
        run_sample(3, 0, "R2 rounding", got);
        check(got, 1, "R2 literal rounding");

        // R3 pass-through cascade: a2h=0.5 gives unity per section
        program_all(2, 24'h400000);
        run_sample(-777, 0, "R3 passthrough negative", got);
        check(got, -777, "R3 literal passthrough");
        run_sample(8388607, 0, "R3 passthrough max", got);
        check(got, 8388607, "R3 literal max");

        // R4 saturation at both range ends
        program_all(2, 24'h7FFFFF);
        run_sample(8388607, 0, "R4 positive saturate", got);
        check(got, 8388607, "R4 literal max clamp");
        run_sample(-8388608, 0, "R4 negative saturate", got);
        check(got, -8388608, "R4 literal min clamp");

        // R5 extreme preset states, feedback active, zero input
        program_all(1, 24'h400000);
        program_all(4, 24'h200000);
        program_all(3, 24'hF00000);
        program_all(6, 24'h7FFFFF);
        program_all(7, 24'h800000);
        for (int i = 0; i < 4; i++) run_sample(0, 0, "R5 preset state response", got);

        // R1/R6 random coefficients and samples
        for (int r = 0; r < 5; r++) begin
            for (int s = 0; s < NSEC; s++)
                for (int f = 0; f < 6; f++)
                    cfg_write(s, f, (f == 5) ? DW'(24'h200000 + ($urandom % 24'h200000))
                                             : DW'($signed(DW'($urandom)) >>> 1));
            for (int i = 0; i < 20; i++)
                run_sample(sx(DW'($urandom)), 0, "R1 random vector", got);
        end

        // R9 write during busy ignored; R8 strobe during busy ignored
        run_sample(sx(DW'($urandom)), 1, "R9 busy write ignored", got);
        run_sample(sx(DW'($urandom)), 0, "R9 coefficients intact", got);
        run_sample(sx(DW'($urandom)), 2, "R8 busy strobe ignored", got);
        begin
            int extra = 0;
            repeat (7 * NSEC + 4) begin
                @(posedge clk);
                @(negedge clk);
                if (out_done) extra++;
            end
            check(extra, 0, "R8 no extra result");
        end

        // R10 reset clears states and coefficients
        program_all(6, 24'h123456);
        program_all(7, 24'h654321);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        check(int'(out_data), 0, "R10 out_data after reset");
        program_all(5, 24'h400000);
        program_all(2, 24'h400000);
        run_sample(4242, 0, "R10 cleared states", got);
        check(got, 4242, "R10 literal after reset");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule